// File: doc/BRIEF.md
# Blocking Fetch and Data-Access Sequencer

This block is the control core of a simple in-order processor that keeps at most one memory transaction outstanding. For each instruction it raises an interrupt-check strobe, sends one instruction fetch, and waits for the response. A load or store that is not a prefetch then makes one data access. Any other instruction executes at once. Every instruction ends with an advance strobe that carries a fault flag. The next fetch starts only if the sequencer is still running at that point.

Both request ports use a valid/accept handshake. The accept input is sampled in the same cycle as valid. When a request is refused, the sequencer keeps it and sends it again only in a cycle where the port raises its retry input. Responses are always taken. Suspend acts lazily: an access already in flight completes, and the sequencer then goes idle instead of fetching again. Switch-out is always acknowledged. A running sequencer that is switched out stays parked until reset.

Top module: `fm_sequencer`

## Requirements
- R1: `state_o` is encoded as 0 idle, 1 running, 2 fetch-retry, 3 fetch-wait, 4 data-retry, 5 data-wait and 6 switched-out. After reset it reads 0, and `proto_err_o` and `sw_done_o` are 0.
- R2: `act_i` in idle moves the state to running in the next cycle and loads the start delay D from `act_delay_i`. The first fetch launch happens D+1 cycles after the `act_i` cycle. `act_i` in any other state has no effect.
- R3: `irq_chk_o` is high exactly in fetch-launch cycles. A launch happens in running when the delay has expired and neither switch-out nor suspend is present.
- R4: At a launch without a fault, `i_valid_o` is high. `i_accept_i` high leads to state 3, and low leads to state 2. In state 2, `i_valid_o` is high only in a cycle with `i_retry_i`, and an accepted resend leads to state 3.
- R5: A launch with `ifault_i` high issues no fetch. It pulses `advance_o` and `adv_fault_o`, the state stays at 1, and the next launch follows in the next cycle.
- R6: `i_rsp_i` in state 3 with `is_mem_i` high and `is_pref_i` low raises `d_valid_o` in the same cycle, with `d_write_o` equal to `is_store_i`. The state then goes to 5 if `d_accept_i` is high and to 4 if it is low. Any other instruction pulses `exec_o` and `advance_o`, with `adv_fault_o` equal to `xfault_i`.
- R7: In state 4, `d_valid_o` is high only in a cycle with `d_retry_i`. It carries the held `d_write_o` of the first attempt, and an accepted resend leads to state 5.
- R8: When `dfault_i` is high at a data initiation, no data request is made. `advance_o` and `adv_fault_o` pulse instead.
- R9: `d_rsp_i` in state 5 pulses `exec_o` and `advance_o`, with `adv_fault_o` equal to `xfault_i`.
- R10: After every advance, the state is 1 with zero delay, or 0 if a suspend was seen since the fetch launched.
- R11: `susp_i` in running moves the state to 0 with no launch. In states 2 to 5 it is remembered until the next advance. In idle and switched-out it has no effect.
- R12: `sw_done_o` is high in the cycle after every `swout_i`. `swout_i` in running moves the state to 6, and it takes priority over suspend and launch. State 6 holds until reset. In all other states `swout_i` leaves the state unchanged.
- R13: `proto_err_o` becomes 1 and stays 1 in the cycle after `i_retry_i` outside state 2 or `d_retry_i` outside state 4. Such retries and responses arriving outside their wait state change nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| act_i | input | 1 | activate request |
| act_delay_i | input | DLY_W | start delay in cycles |
| susp_i | input | 1 | suspend request |
| swout_i | input | 1 | switch-out request |
| ifault_i | input | 1 | fetch translation fault, valid in launch cycle |
| is_mem_i | input | 1 | decode hint: memory reference |
| is_pref_i | input | 1 | decode hint: data prefetch |
| is_store_i | input | 1 | decode hint: access writes |
| dfault_i | input | 1 | data initiation fault |
| xfault_i | input | 1 | execution/completion fault |
| i_valid_o | output | 1 | fetch request valid |
| i_accept_i | input | 1 | fetch port accepts this cycle |
| i_retry_i | input | 1 | fetch port retry notification |
| i_rsp_i | input | 1 | fetch response valid |
| d_valid_o | output | 1 | data request valid |
| d_write_o | output | 1 | data request is a write |
| d_accept_i | input | 1 | data port accepts this cycle |
| d_retry_i | input | 1 | data port retry notification |
| d_rsp_i | input | 1 | data response valid |
| irq_chk_o | output | 1 | interrupt-check strobe |
| exec_o | output | 1 | execute/complete strobe |
| advance_o | output | 1 | advance strobe |
| adv_fault_o | output | 1 | advance carries a fault |
| sw_done_o | output | 1 | switch-out acknowledge |
| state_o | output | 3 | sequencer state |
| proto_err_o | output | 1 | sticky retry protocol error |

## Verification
The bench builds the sequencer with `DLY_W` = 3. The whole start-delay range, including the largest value 7 and its wrap-free countdown, can then be reached by both directed activations and random ones. A cycle-level reference model runs alongside the design. Directed sequences cover each refusal, retry, fault and suspend path. Reset-separated random segments then mix hazards such as suspends during retry waits, spurious retries and switch-out.

// File: rtl/fm_seq_pkg.sv
package fm_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RUN    = 3'd1,
        ST_IRETRY = 3'd2,
        ST_IWAIT  = 3'd3,
        ST_DRETRY = 3'd4,
        ST_DWAIT  = 3'd5,
        ST_SWOUT  = 3'd6
    } fm_state_e;

    typedef struct packed {
        fm_state_e st;
        logic      kind;
        logic      susp_pend;
        logic      swack;
    } fm_regs_t;

    localparam int unsigned FM_NPORT = 2;

endpackage

// File: rtl/fm_launch_timer.sv
module fm_launch_timer #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         dec_i,
    output logic         zero_o
);
    localparam logic [W-1:0] CNT_ZERO = '0;
    localparam logic [W-1:0] CNT_ONE  = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (dec_i && cnt_q != CNT_ZERO)
            cnt_d = cnt_q - CNT_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CNT_ZERO;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == CNT_ZERO);
endmodule

// File: rtl/fm_retry_guard.sv
module fm_retry_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic retry_i,
    input  logic held_i,
    output logic err_o
);
    logic err_d, err_q;

    always_comb err_d = err_q | (retry_i & ~held_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign err_o = err_q;
endmodule

// File: rtl/fm_sequencer.sv
module fm_sequencer
    import fm_seq_pkg::*;
#(
    parameter int unsigned DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic [DLY_W-1:0] act_delay_i,
    input  logic             susp_i,
    input  logic             swout_i,
    input  logic             ifault_i,
    input  logic             is_mem_i,
    input  logic             is_pref_i,
    input  logic             is_store_i,
    input  logic             dfault_i,
    input  logic             xfault_i,
    output logic             i_valid_o,
    input  logic             i_accept_i,
    input  logic             i_retry_i,
    input  logic             i_rsp_i,
    output logic             d_valid_o,
    output logic             d_write_o,
    input  logic             d_accept_i,
    input  logic             d_retry_i,
    input  logic             d_rsp_i,
    output logic             irq_chk_o,
    output logic             exec_o,
    output logic             advance_o,
    output logic             adv_fault_o,
    output logic             sw_done_o,
    output logic [2:0]       state_o,
    output logic             proto_err_o
);
    localparam logic [DLY_W-1:0] DLY_NONE = '0;

    fm_regs_t         r_q, r_d;
    logic             tmr_load, tmr_dec, tmr_zero;
    logic [DLY_W-1:0] tmr_val;
    logic             in_flight, susp_eff, adv;

    logic [FM_NPORT-1:0] retry_vec, held_vec, err_vec;

    fm_launch_timer #(.W(DLY_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .dec_i  (tmr_dec),
        .zero_o (tmr_zero)
    );

    assign retry_vec = {d_retry_i, i_retry_i};
    assign held_vec  = {r_q.st == ST_DRETRY, r_q.st == ST_IRETRY};

    for (genvar p = 0; p < FM_NPORT; p++) begin : g_guard
        fm_retry_guard u_guard (
            .clk     (clk),
            .rst_n   (rst_n),
            .retry_i (retry_vec[p]),
            .held_i  (held_vec[p]),
            .err_o   (err_vec[p])
        );
    end

    always_comb begin
        r_d         = r_q;
        r_d.swack   = swout_i;
        tmr_load    = 1'b0;
        tmr_val     = DLY_NONE;
        tmr_dec     = 1'b0;
        i_valid_o   = 1'b0;
        d_valid_o   = 1'b0;
        d_write_o   = (r_q.st == ST_DRETRY) ? r_q.kind : is_store_i;
        irq_chk_o   = 1'b0;
        exec_o      = 1'b0;
        adv         = 1'b0;
        adv_fault_o = 1'b0;

        in_flight = (r_q.st == ST_IRETRY) || (r_q.st == ST_IWAIT) ||
                    (r_q.st == ST_DRETRY) || (r_q.st == ST_DWAIT);
        susp_eff      = r_q.susp_pend | (susp_i & in_flight);
        r_d.susp_pend = susp_eff;

        case (r_q.st)
            ST_IDLE: begin
                if (act_i) begin
                    r_d.st   = ST_RUN;
                    tmr_load = 1'b1;
                    tmr_val  = act_delay_i;
                end
            end
            ST_RUN: begin
                if (swout_i) begin
                    r_d.st = ST_SWOUT;
                end else if (susp_i) begin
                    r_d.st = ST_IDLE;
                end else if (!tmr_zero) begin
                    tmr_dec = 1'b1;
                end else begin
                    irq_chk_o = 1'b1;
                    if (ifault_i) begin
                        adv         = 1'b1;
                        adv_fault_o = 1'b1;
                    end else begin
                        i_valid_o = 1'b1;
                        r_d.st    = i_accept_i ? ST_IWAIT : ST_IRETRY;
                    end
                end
            end
            ST_IRETRY: begin
                if (i_retry_i) begin
                    i_valid_o = 1'b1;
                    if (i_accept_i) r_d.st = ST_IWAIT;
                end
            end
            ST_IWAIT: begin
                if (i_rsp_i) begin
                    if (is_mem_i && !is_pref_i) begin
                        if (dfault_i) begin
                            adv         = 1'b1;
                            adv_fault_o = 1'b1;
                        end else begin
                            d_valid_o = 1'b1;
                            r_d.kind  = is_store_i;
                            r_d.st    = d_accept_i ? ST_DWAIT : ST_DRETRY;
                        end
                    end else begin
                        exec_o      = 1'b1;
                        adv         = 1'b1;
                        adv_fault_o = xfault_i;
                    end
                end
            end
            ST_DRETRY: begin
                if (d_retry_i) begin
                    d_valid_o = 1'b1;
                    if (d_accept_i) r_d.st = ST_DWAIT;
                end
            end
            ST_DWAIT: begin
                if (d_rsp_i) begin
                    exec_o      = 1'b1;
                    adv         = 1'b1;
                    adv_fault_o = xfault_i;
                end
            end
            default: ;
        endcase

        if (adv) begin
            r_d.st        = susp_eff ? ST_IDLE : ST_RUN;
            r_d.susp_pend = 1'b0;
            tmr_load      = 1'b1;
            tmr_val       = DLY_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st        <= ST_IDLE;
            r_q.kind      <= 1'b0;
            r_q.susp_pend <= 1'b0;
            r_q.swack     <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign advance_o   = adv;
    assign sw_done_o   = r_q.swack;
    assign state_o     = r_q.st;
    assign proto_err_o = |err_vec;
endmodule

// File: rtl/fm_sequencer_chk.sv
module fm_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       act_i,
    input logic       swout_i,
    input logic       i_retry_i,
    input logic       d_retry_i,
    input logic       i_valid_o,
    input logic       d_valid_o,
    input logic       irq_chk_o,
    input logic       advance_o,
    input logic       sw_done_o,
    input logic [2:0] state_o,
    input logic       proto_err_o
);
    p_one_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({i_valid_o, d_valid_o}));

    p_ivalid_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
        i_valid_o |-> (state_o == 3'd1 || state_o == 3'd2));

    p_dvalid_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        d_valid_o |-> (state_o == 3'd3 || state_o == 3'd4));

    p_ihold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && !i_retry_i) |=> state_o == 3'd2);

    p_dhold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4 && !d_retry_i) |=> state_o == 3'd4);

    p_activate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && act_i) |=> state_o == 3'd1);

    p_irq_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_chk_o |-> (state_o == 3'd1 && (i_valid_o || advance_o)));

    p_swack_r12: assert property (@(posedge clk) disable iff (!rst_n)
        swout_i |=> sw_done_o);

    p_parked_r12: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 3'd6 |=> state_o == 3'd6);

    p_err_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |=> proto_err_o);
endmodule

bind fm_sequencer fm_sequencer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .act_i       (act_i),
    .swout_i     (swout_i),
    .i_retry_i   (i_retry_i),
    .d_retry_i   (d_retry_i),
    .i_valid_o   (i_valid_o),
    .d_valid_o   (d_valid_o),
    .irq_chk_o   (irq_chk_o),
    .advance_o   (advance_o),
    .sw_done_o   (sw_done_o),
    .state_o     (state_o),
    .proto_err_o (proto_err_o)
);

// File: tb/fm_sequencer_tb.sv
module fm_sequencer_tb;
    localparam int DW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic act_i, susp_i, swout_i, ifault_i, is_mem_i, is_pref_i, is_store_i;
    logic dfault_i, xfault_i, i_accept_i, i_retry_i, i_rsp_i;
    logic d_accept_i, d_retry_i, d_rsp_i;
    logic [DW-1:0] act_delay_i;
    logic i_valid_o, d_valid_o, d_write_o, irq_chk_o, exec_o, advance_o;
    logic adv_fault_o, sw_done_o, proto_err_o;
    logic [2:0] state_o;

    always #5 clk = ~clk;

    fm_sequencer #(.DLY_W(DW)) u_dut (.*);

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference model state
    int mst, mcnt;
    bit mkind, msusp, mack, merr;

    task automatic clear_in();
        act_i = 0; susp_i = 0; swout_i = 0; ifault_i = 0; is_mem_i = 0;
        is_pref_i = 0; is_store_i = 0; dfault_i = 0; xfault_i = 0;
        i_accept_i = 0; i_retry_i = 0; i_rsp_i = 0; d_accept_i = 0;
        d_retry_i = 0; d_rsp_i = 0; act_delay_i = '0;
    endtask

    task automatic model_reset();
        mst = 0; mcnt = 0; mkind = 0; msusp = 0; mack = 0; merr = 0;
    endtask

    task automatic chk(string sig, int act, int exp);
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", cur_req, sig, act, exp, $time);
        end
    endtask

    // one clock: compare outputs against the model, then advance the model
    task automatic cyc();
        bit e_iv, e_dv, e_dw, e_irq, e_ex, e_adv, e_af, busy, seff;
        int nst, ncnt;
        bit nkind, nsusp;
        #1;
        e_iv = 0; e_dv = 0; e_dw = 0; e_irq = 0; e_ex = 0; e_adv = 0; e_af = 0;
        nst = mst; ncnt = mcnt; nkind = mkind;
        busy = (mst >= 2 && mst <= 5);
        seff = msusp || (susp_i && busy);
        nsusp = seff;
        if (mst == 0 && act_i) begin
            nst = 1; ncnt = int'(act_delay_i);
        end else if (mst == 1) begin
            if (swout_i) nst = 6;
            else if (susp_i) nst = 0;
            else if (mcnt > 0) ncnt = mcnt - 1;
            else begin
                e_irq = 1;
                if (ifault_i) begin e_adv = 1; e_af = 1; end
                else begin e_iv = 1; nst = i_accept_i ? 3 : 2; end
            end
        end else if (mst == 2 && i_retry_i) begin
            e_iv = 1; if (i_accept_i) nst = 3;
        end else if (mst == 3 && i_rsp_i) begin
            if (is_mem_i && !is_pref_i) begin
                if (dfault_i) begin e_adv = 1; e_af = 1; end
                else begin
                    e_dv = 1; e_dw = is_store_i; nkind = is_store_i;
                    nst = d_accept_i ? 5 : 4;
                end
            end else begin
                e_ex = 1; e_adv = 1; e_af = xfault_i;
            end
        end else if (mst == 4) begin
            e_dw = mkind;
            if (d_retry_i) begin e_dv = 1; if (d_accept_i) nst = 5; end
        end else if (mst == 5 && d_rsp_i) begin
            e_ex = 1; e_adv = 1; e_af = xfault_i;
        end
        if (e_adv) begin nst = seff ? 0 : 1; nsusp = 0; ncnt = 0; end

        vectors++;
        chk("state_o", int'(state_o), mst);
        chk("proto_err_o", int'(proto_err_o), int'(merr));
        chk("sw_done_o", int'(sw_done_o), int'(mack));
        chk("i_valid_o", int'(i_valid_o), int'(e_iv));
        chk("d_valid_o", int'(d_valid_o), int'(e_dv));
        if (e_dv) chk("d_write_o", int'(d_write_o), int'(e_dw));
        chk("irq_chk_o", int'(irq_chk_o), int'(e_irq));
        chk("exec_o", int'(exec_o), int'(e_ex));
        chk("advance_o", int'(advance_o), int'(e_adv));
        chk("adv_fault_o", int'(adv_fault_o), int'(e_af));

        if (!rst_n) model_reset();
        else begin
            merr = merr | (i_retry_i && mst != 2) | (d_retry_i && mst != 4);
            mack = swout_i;
            mst = nst; mcnt = ncnt; mkind = nkind; msusp = nsusp;
        end
        @(negedge clk);
        #1;
        clear_in();
    endtask

    task automatic do_reset();
        cur_req = "R1";
        rst_n = 0;
        model_reset();
        clear_in();
        cyc(); cyc();
        rst_n = 1;
        cyc();
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    initial begin
        clear_in();
        model_reset();
        @(negedge clk); #1;
        do_reset();

        // R2: activate with delay 2, activate again while running is ignored
        cur_req = "R2";
        act_i = 1; act_delay_i = 3'd2; cyc();
        act_i = 1; act_delay_i = 3'd5; cyc();
        cyc();
        // R3 R4: launch accepted
        cur_req = "R4";
        i_accept_i = 1; cyc();
        // R6: non-memory instruction executes, with execution fault
        cur_req = "R6";
        i_rsp_i = 1; xfault_i = 1; cyc();
        // R4: refused fetch, retry refused, retry accepted
        cur_req = "R4";
        i_accept_i = 0; cyc();
        idle(2);
        i_retry_i = 1; cyc();
        i_retry_i = 1; i_accept_i = 1; cyc();
        // R13: response outside wait ignored is already covered; spurious data retry here
        cur_req = "R13";
        d_retry_i = 1; cyc();
        // R6 R7: store refused, held kind resent
        cur_req = "R7";
        i_rsp_i = 1; is_mem_i = 1; is_store_i = 1; d_accept_i = 0; cyc();
        cyc();
        d_retry_i = 1; d_accept_i = 1; is_store_i = 0; cyc();
        // R9: data response completes
        cur_req = "R9";
        d_rsp_i = 1; cyc();
        // R5: fetch translation fault then normal launch
        cur_req = "R5";
        ifault_i = 1; cyc();
        i_accept_i = 1; cyc();
        // R8: data initiation fault
        cur_req = "R8";
        i_rsp_i = 1; is_mem_i = 1; dfault_i = 1; cyc();
        // R6: prefetch executes immediately
        cur_req = "R6";
        i_accept_i = 1; cyc();
        i_rsp_i = 1; is_mem_i = 1; is_pref_i = 1; cyc();
        // R6: load accepted first time
        i_accept_i = 1; cyc();
        i_rsp_i = 1; is_mem_i = 1; d_accept_i = 1; cyc();
        // R11 R10: lazy suspend while data access in flight
        cur_req = "R10";
        susp_i = 1; cyc();
        d_rsp_i = 1; cyc();
        idle(2);
        // R11: suspend in idle ignored, then suspend while running
        cur_req = "R11";
        susp_i = 1; cyc();
        act_i = 1; act_delay_i = 3'd7; cyc();
        idle(3);
        susp_i = 1; cyc();
        idle(2);
        // R13: stray fetch retry and response in idle
        cur_req = "R13";
        i_retry_i = 1; i_rsp_i = 1; cyc();
        idle(2);
        // R12: switch-out in wait is acknowledged only, then parks from running
        cur_req = "R12";
        act_i = 1; cyc();
        i_accept_i = 1; cyc();
        swout_i = 1; cyc();
        i_rsp_i = 1; cyc();
        swout_i = 1; susp_i = 1; cyc();
        act_i = 1; cyc();
        idle(2);

        // R1..R13 mixed: reset-separated random segments
        cur_req = "R10";
        for (int seg = 0; seg < 6; seg++) begin
            do_reset();
            cur_req = "R6";
            for (int k = 0; k < 800; k++) begin
                act_i = ($urandom % 6) == 0;
                act_delay_i = DW'($urandom);
                susp_i = ($urandom % 20) == 0;
                swout_i = ($urandom % 150) == 0;
                ifault_i = ($urandom % 8) == 0;
                is_mem_i = $urandom % 2;
                is_pref_i = ($urandom % 4) == 0;
                is_store_i = $urandom % 2;
                dfault_i = ($urandom % 8) == 0;
                xfault_i = ($urandom % 4) == 0;
                i_accept_i = $urandom % 2;
                i_retry_i = ($urandom % 3) == 0;
                i_rsp_i = ($urandom % 3) == 0;
                d_accept_i = $urandom % 2;
                d_retry_i = ($urandom % 3) == 0;
                d_rsp_i = ($urandom % 3) == 0;
                cyc();
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule